// File: doc/BRIEF.md
# Split Application/Kernel Cache Tag Controller

This block holds the tags for two small set-associative caches. One cache serves application traffic and the other serves kernel traffic, and both share the same set count. Each request is routed to its home cache by the supervisor bit and the shared bit. A request with the supervisor bit set and the shared bit clear goes to the kernel cache. All other requests go to the application cache, including kernel requests for data shared with user code.

When a miss finds its home set full, the line may be placed in the same set of the other cache. This is allowed only if that set has a free way and fewer than half of its ways already hold such borrowed lines. A borrowed line is the first candidate for eviction in the cache that holds it.

Each home set has an overflow bit that marks that some of its lines may live in the other cache. While the bit is set, a home miss costs one extra cycle to probe the other cache. The bit clears once a probe finds that no borrowed lines for the set remain. Misses report a fill request to the next level, and a displaced valid line is reported as an eviction.

Top module: `duo_tag_ctrl`

## Requirements
- R1: A request with `req_sup`=1 and `req_shared`=0 has the kernel cache (`resp_cache`=1) as its home. A request with `req_sup`=0 has the application cache (`resp_cache`=0) as its home. When the home set has a free way, a miss is placed at the lowest-numbered free way there.
- R2: A request with `req_shared`=1 always has the application cache as its home, whatever `req_sup` is.
- R3: A hit in the home cache produces a one-cycle `resp_valid` with `resp_hit`=1 in the cycle after the accepting edge, reporting the cache and way that hit.
- R4: A line is held in at most one of the two caches. A line found in the other cache is not copied into its home cache.
- R5: A miss whose home set is full is placed in the other cache's same set when that set has a free way and holds fewer than half its ways of borrowed lines. Such a placement evicts nothing, and the borrowed count never exceeds half the ways.
- R6: A miss responds with `resp_hit`=0 and, in the same cycle, `fill_valid`=1 with `fill_addr` equal to the request address. `resp_cache`/`resp_way` give where the line was placed. With the overflow bit clear, this happens two cycles after the accepting edge.
- R7: With the home set's overflow bit set, a home miss probes the other cache. A hit there responds two cycles after acceptance, reporting the other cache. A miss there responds three cycles after acceptance.
- R8: The overflow bit is set by a placement in the other cache. It clears when a probe finds no borrowed lines for that set, after which misses in that set take two cycles again.
- R9: When no free way can be used, the home cache evicts its lowest-numbered borrowed line if it holds any, and otherwise its least recently used native line. `evict_valid`=1 and `evict_addr` (victim tag above the set index) accompany the fill.
- R10: `req_ready` is 1 after reset and when idle. It is 0 from the accepting edge until the response has been given. After reset, `resp_valid`, `fill_valid` and `evict_valid` are 0.

The address's low log2(SETS) bits select the set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_addr | input | ADDR_W | Line address; low bits are the set index |
| req_sup | input | 1 | Request issued in supervisor mode |
| req_shared | input | 1 | Line is shared between user and kernel |
| req_ready | output | 1 | Controller idle, request accepted on this edge |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_hit | output | 1 | 1 = hit, 0 = miss |
| resp_cache | output | 1 | Cache that hit or received the fill: 0 application, 1 kernel |
| resp_way | output | WAY_W | Way that hit or received the fill |
| fill_valid | output | 1 | Fetch request to the next level |
| fill_addr | output | ADDR_W | Line address to fetch |
| evict_valid | output | 1 | A valid line was displaced |
| evict_addr | output | ADDR_W | Address of the displaced line |

## Verification
Every result is due a fixed number of clock edges after the accepting edge. A home hit takes one edge. A miss with the overflow bit clear, or a hit in the other cache during a probe, takes two. A miss that also misses during the probe takes three. Fill and eviction outputs arrive in the same cycle as the miss response. The bench counts rising edges from acceptance and samples on falling edges until `resp_valid` appears. It then compares that count with the expected latency, so a response that is early, late or missing is reported rather than skipped.

// File: rtl/duo_pkg.sv
package duo_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HOME,
        ST_PROBE,
        ST_FILL
    } duo_state_e;

    localparam logic SIDE_APP = 1'b0;
    localparam logic SIDE_OS  = 1'b1;

endpackage

// File: rtl/duo_tag_bank.sv
module duo_tag_bank #(
    parameter int SETS  = 4,
    parameter int WAYS  = 4,
    parameter int TAG_W = 10,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS),
    localparam int CNT_W = $clog2(WAYS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    input  logic             wr_en,
    input  logic             wr_spill,
    input  logic             touch_en,
    input  logic [WAY_W-1:0] sel_way,
    output logic             hit,
    output logic [WAY_W-1:0] hit_way,
    output logic             free_any,
    output logic [WAY_W-1:0] free_way,
    output logic [CNT_W-1:0] spill_cnt,
    output logic [WAY_W-1:0] victim_way,
    output logic [TAG_W-1:0] victim_tag
);

    logic [TAG_W-1:0] tag_q [SETS][WAYS];
    logic [WAYS-1:0]  vld_q [SETS];
    logic [WAYS-1:0]  spl_q [SETS];
    logic [WAY_W-1:0] age_q [SETS][WAYS];

    logic             any_spl;
    logic [WAY_W-1:0] spl_way;
    logic [WAY_W-1:0] lru_way;
    logic [WAY_W-1:0] lru_age;
    logic [WAY_W-1:0] sel_age;

    always_comb begin
        hit       = 1'b0;
        hit_way   = '0;
        free_any  = 1'b0;
        free_way  = '0;
        spill_cnt = '0;
        any_spl   = 1'b0;
        spl_way   = '0;
        lru_way   = '0;
        lru_age   = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (vld_q[lk_idx][w] && tag_q[lk_idx][w] == lk_tag) begin
                hit     = 1'b1;
                hit_way = WAY_W'(w);
            end
            if (!vld_q[lk_idx][w] && !free_any) begin
                free_any = 1'b1;
                free_way = WAY_W'(w);
            end
            if (vld_q[lk_idx][w] && spl_q[lk_idx][w]) begin
                spill_cnt = spill_cnt + CNT_W'(1);
                if (!any_spl) begin
                    any_spl = 1'b1;
                    spl_way = WAY_W'(w);
                end
            end
            if (!spl_q[lk_idx][w] && age_q[lk_idx][w] >= lru_age) begin
                lru_age = age_q[lk_idx][w];
                lru_way = WAY_W'(w);
            end
        end
        victim_way = any_spl ? spl_way : lru_way;
        victim_tag = tag_q[lk_idx][victim_way];
        sel_age    = age_q[lk_idx][sel_way];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
                spl_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) begin
                    tag_q[s][w] <= '0;
                    age_q[s][w] <= WAY_W'(w);
                end
            end
        end else begin
            if (wr_en) begin
                tag_q[lk_idx][sel_way] <= lk_tag;
                vld_q[lk_idx][sel_way] <= 1'b1;
                spl_q[lk_idx][sel_way] <= wr_spill;
            end
            if (touch_en) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (WAY_W'(w) == sel_way) begin
                        age_q[lk_idx][w] <= '0;
                    end else if (age_q[lk_idx][w] < sel_age) begin
                        age_q[lk_idx][w] <= age_q[lk_idx][w] + WAY_W'(1);
                    end
                end
            end
        end
    end

endmodule

// File: rtl/duo_tag_ctrl.sv
module duo_tag_ctrl
    import duo_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int SETS     = 4,
    parameter int APP_WAYS = 4,
    parameter int OS_WAYS  = 4,
    localparam int IDX_W   = $clog2(SETS),
    localparam int TAG_W   = ADDR_W - IDX_W,
    localparam int MAX_W   = (APP_WAYS > OS_WAYS) ? APP_WAYS : OS_WAYS,
    localparam int WAY_W   = $clog2(MAX_W),
    localparam int CNT_W   = $clog2(MAX_W + 1),
    localparam int APP_CAP = APP_WAYS / 2,
    localparam int OS_CAP  = OS_WAYS / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_sup,
    input  logic              req_shared,
    output logic              req_ready,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic              resp_cache,
    output logic [WAY_W-1:0]  resp_way,
    output logic              fill_valid,
    output logic [ADDR_W-1:0] fill_addr,
    output logic              evict_valid,
    output logic [ADDR_W-1:0] evict_addr
);

    duo_state_e        state_q, state_d;
    logic [ADDR_W-1:0] r_addr;
    logic              h_side;
    logic              o_side;
    logic [SETS-1:0]   ovf_q [2];

    logic [IDX_W-1:0]  idx;
    logic [TAG_W-1:0]  tag;

    logic [1:0]        hit_s;
    logic [1:0]        free_s;
    logic [WAY_W-1:0]  hit_way_s  [2];
    logic [WAY_W-1:0]  free_way_s [2];
    logic [WAY_W-1:0]  vict_way_s [2];
    logic [TAG_W-1:0]  vict_tag_s [2];
    logic [CNT_W-1:0]  cnt_s      [2];
    logic [1:0]        wr_en_s;
    logic [1:0]        touch_s;
    logic [WAY_W-1:0]  way_s      [2];

    logic              fill_spill;
    logic              fill_side;
    logic [WAY_W-1:0]  fill_way;
    logic              fill_evict;
    logic [CNT_W-1:0]  cap_o;

    assign idx       = r_addr[IDX_W-1:0];
    assign tag       = r_addr[ADDR_W-1:IDX_W];
    assign o_side    = ~h_side;
    assign req_ready = (state_q == ST_IDLE);
    assign cap_o     = (o_side == SIDE_OS) ? CNT_W'(OS_CAP) : CNT_W'(APP_CAP);

    for (genvar g = 0; g < 2; g++) begin : g_bank
        localparam int BW  = (g == 0) ? APP_WAYS : OS_WAYS;
        localparam int BWW = $clog2(BW);
        localparam int BCW = $clog2(BW + 1);
        logic           b_hit, b_free;
        logic [BWW-1:0] b_hit_way, b_free_way, b_vict_way;
        logic [BCW-1:0] b_cnt;

        duo_tag_bank #(.SETS(SETS), .WAYS(BW), .TAG_W(TAG_W)) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .lk_idx     (idx),
            .lk_tag     (tag),
            .wr_en      (wr_en_s[g]),
            .wr_spill   (fill_spill),
            .touch_en   (touch_s[g]),
            .sel_way    (way_s[g][BWW-1:0]),
            .hit        (b_hit),
            .hit_way    (b_hit_way),
            .free_any   (b_free),
            .free_way   (b_free_way),
            .spill_cnt  (b_cnt),
            .victim_way (b_vict_way),
            .victim_tag (vict_tag_s[g])
        );

        assign hit_s[g]      = b_hit;
        assign free_s[g]     = b_free;
        assign hit_way_s[g]  = WAY_W'(b_hit_way);
        assign free_way_s[g] = WAY_W'(b_free_way);
        assign vict_way_s[g] = WAY_W'(b_vict_way);
        assign cnt_s[g]      = CNT_W'(b_cnt);
    end

    // Placement choice for a miss: free home way, else borrow, else evict.
    always_comb begin
        fill_spill = !free_s[h_side] && free_s[o_side] && (cnt_s[o_side] < cap_o);
        fill_side  = fill_spill ? o_side : h_side;
        fill_evict = !free_s[h_side] && !fill_spill;
        if (free_s[h_side]) begin
            fill_way = free_way_s[h_side];
        end else if (fill_spill) begin
            fill_way = free_way_s[o_side];
        end else begin
            fill_way = vict_way_s[h_side];
        end
    end

    always_comb begin
        for (int g = 0; g < 2; g++) begin
            wr_en_s[g] = (state_q == ST_FILL) && (fill_side == 1'(g));
            touch_s[g] = wr_en_s[g]
                       || ((state_q == ST_HOME)  && (h_side == 1'(g)) && hit_s[g])
                       || ((state_q == ST_PROBE) && (o_side == 1'(g)) && hit_s[g]);
            way_s[g]   = (state_q == ST_FILL) ? fill_way : hit_way_s[g];
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_HOME;
            ST_HOME: begin
                if (hit_s[h_side])          state_d = ST_IDLE;
                else if (ovf_q[h_side][idx]) state_d = ST_PROBE;
                else                        state_d = ST_FILL;
            end
            ST_PROBE: state_d = hit_s[o_side] ? ST_IDLE : ST_FILL;
            ST_FILL:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_addr   <= '0;
            h_side   <= SIDE_APP;
            ovf_q[0] <= '0;
            ovf_q[1] <= '0;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                r_addr <= req_addr;
                h_side <= (req_sup && !req_shared) ? SIDE_OS : SIDE_APP;
            end
            if (state_q == ST_FILL && fill_spill) begin
                ovf_q[h_side][idx] <= 1'b1;
            end
            if (state_q == ST_PROBE && !hit_s[o_side] && cnt_s[o_side] == '0) begin
                ovf_q[h_side][idx] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid  <= 1'b0;
            resp_hit    <= 1'b0;
            resp_cache  <= SIDE_APP;
            resp_way    <= '0;
            fill_valid  <= 1'b0;
            fill_addr   <= '0;
            evict_valid <= 1'b0;
            evict_addr  <= '0;
        end else begin
            resp_valid  <= 1'b0;
            fill_valid  <= 1'b0;
            evict_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: ;
                ST_HOME: begin
                    if (hit_s[h_side]) begin
                        resp_valid <= 1'b1;
                        resp_hit   <= 1'b1;
                        resp_cache <= h_side;
                        resp_way   <= hit_way_s[h_side];
                    end
                end
                ST_PROBE: begin
                    if (hit_s[o_side]) begin
                        resp_valid <= 1'b1;
                        resp_hit   <= 1'b1;
                        resp_cache <= o_side;
                        resp_way   <= hit_way_s[o_side];
                    end
                end
                ST_FILL: begin
                    resp_valid  <= 1'b1;
                    resp_hit    <= 1'b0;
                    resp_cache  <= fill_side;
                    resp_way    <= fill_way;
                    fill_valid  <= 1'b1;
                    fill_addr   <= r_addr;
                    evict_valid <= fill_evict;
                    evict_addr  <= {vict_tag_s[h_side], idx};
                end
            endcase
        end
    end

endmodule

// File: rtl/duo_tag_chk.sv
module duo_tag_chk
    import duo_pkg::*;
#(
    parameter int CNT_W   = 3,
    parameter int APP_CAP = 2,
    parameter int OS_CAP  = 2
) (
    input logic             clk,
    input logic             rst_n,
    input duo_state_e       state,
    input logic             req_valid,
    input logic             req_ready,
    input logic             resp_valid,
    input logic             resp_hit,
    input logic             fill_valid,
    input logic             evict_valid,
    input logic             app_hit,
    input logic             os_hit,
    input logic [CNT_W-1:0] app_spill_cnt,
    input logic [CNT_W-1:0] os_spill_cnt
);

    p_resp_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    p_single_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL) |-> !(app_hit || os_hit));

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (app_spill_cnt <= CNT_W'(APP_CAP)) && (os_spill_cnt <= CNT_W'(OS_CAP)));

    p_fill_is_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> (resp_valid && !resp_hit));

    p_probe_after_home_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROBE) |-> ($past(state) == ST_HOME));

    p_evict_with_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
        evict_valid |-> fill_valid);

    p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

endmodule

bind duo_tag_ctrl duo_tag_chk #(
    .CNT_W  (CNT_W),
    .APP_CAP(APP_CAP),
    .OS_CAP (OS_CAP)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .state        (state_q),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .resp_valid   (resp_valid),
    .resp_hit     (resp_hit),
    .fill_valid   (fill_valid),
    .evict_valid  (evict_valid),
    .app_hit      (hit_s[0]),
    .os_hit       (hit_s[1]),
    .app_spill_cnt(cnt_s[0]),
    .os_spill_cnt (cnt_s[1])
);

// File: tb/tb_duo_tag_ctrl.sv
`timescale 1ns/1ps
module tb_duo_tag_ctrl;

    localparam int ADDR_W = 12;
    localparam int WAY_W  = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_sup = 1'b0;
    logic              req_shared = 1'b0;
    logic              req_ready;
    logic              resp_valid;
    logic              resp_hit;
    logic              resp_cache;
    logic [WAY_W-1:0]  resp_way;
    logic              fill_valid;
    logic [ADDR_W-1:0] fill_addr;
    logic              evict_valid;
    logic [ADDR_W-1:0] evict_addr;

    int checks = 0;
    int errors = 0;
    int g_lat, g_hit, g_cache, g_way, g_fill, g_faddr, g_evict, g_eaddr;

    always #2 clk = ~clk;

    duo_tag_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_sup(req_sup), .req_shared(req_shared), .req_ready(req_ready),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_cache(resp_cache),
        .resp_way(resp_way), .fill_valid(fill_valid), .fill_addr(fill_addr),
        .evict_valid(evict_valid), .evict_addr(evict_addr)
    );

    task automatic chk(input string tagname, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tagname, what, act, exp);
        end
    endtask

    task automatic access(input int addr, input bit sup, input bit sh);
        @(negedge clk);
        req_valid  = 1'b1;
        req_addr   = ADDR_W'(addr);
        req_sup    = sup;
        req_shared = sh;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10", "ready low while busy", int'(req_ready), 0);
        g_lat = 0;
        while (1) begin
            @(posedge clk);
            g_lat++;
            @(negedge clk);
            if (resp_valid || g_lat > 8) break;
        end
        g_hit = resp_hit; g_cache = resp_cache; g_way = resp_way;
        g_fill = fill_valid; g_faddr = fill_addr;
        g_evict = evict_valid; g_eaddr = evict_addr;
    endtask

    task automatic expect_miss(input string r, input int addr, input int lat,
                               input int cache, input int way, input int ev, input int eaddr);
        chk(r, "latency", g_lat, lat);
        chk(r, "hit", g_hit, 0);
        chk(r, "cache", g_cache, cache);
        chk(r, "way", g_way, way);
        chk("R6", "fill_valid", g_fill, 1);
        chk("R6", "fill_addr", g_faddr, addr);
        chk(r, "evict_valid", g_evict, ev);
        if (ev != 0) chk(r, "evict_addr", g_eaddr, eaddr);
    endtask

    task automatic expect_hit(input string r, input int lat, input int cache, input int way);
        chk(r, "latency", g_lat, lat);
        chk(r, "hit", g_hit, 1);
        chk(r, "cache", g_cache, cache);
        chk(r, "way", g_way, way);
        chk(r, "no fill on hit", g_fill, 0);
    endtask

    task automatic t_reset;
        chk("R10", "ready after reset", int'(req_ready), 1);
        chk("R10", "resp_valid after reset", int'(resp_valid), 0);
        chk("R10", "fill_valid after reset", int'(fill_valid), 0);
        chk("R10", "evict_valid after reset", int'(evict_valid), 0);
    endtask

    task automatic t_route;
        access('h010, 0, 0); expect_miss("R1", 'h010, 2, 0, 0, 0, 0);
        access('h021, 1, 0); expect_miss("R1", 'h021, 2, 1, 0, 0, 0);
        access('h032, 1, 1); expect_miss("R2", 'h032, 2, 0, 0, 0, 0);
        access('h010, 0, 0); expect_hit("R3", 1, 0, 0);
        access('h032, 1, 1); expect_hit("R2", 1, 0, 0);
        @(negedge clk);
        chk("R10", "ready when idle", int'(req_ready), 1);
    endtask

    task automatic t_spill;
        access('h020, 0, 0); expect_miss("R1", 'h020, 2, 0, 1, 0, 0);
        access('h030, 0, 0); expect_miss("R1", 'h030, 2, 0, 2, 0, 0);
        access('h040, 0, 0); expect_miss("R1", 'h040, 2, 0, 3, 0, 0);
        access('h050, 0, 0); expect_miss("R5", 'h050, 2, 1, 0, 0, 0);
        access('h060, 0, 0); expect_miss("R7", 'h060, 3, 1, 1, 0, 0);
        // cap of two borrowed lines reached: evict LRU native app line
        access('h070, 0, 0); expect_miss("R9", 'h070, 3, 0, 0, 1, 'h010);
    endtask

    task automatic t_probe;
        access('h050, 0, 0); expect_hit("R7", 2, 1, 0);
        access('h050, 0, 0); expect_hit("R4", 2, 1, 0);
    endtask

    task automatic t_os_evict;
        access('h104, 1, 0); expect_miss("R1", 'h104, 2, 1, 2, 0, 0);
        access('h108, 1, 0); expect_miss("R1", 'h108, 2, 1, 3, 0, 0);
        access('h10C, 1, 0); expect_miss("R9", 'h10C, 2, 1, 0, 1, 'h050);
        access('h050, 0, 0); expect_miss("R9", 'h050, 3, 0, 1, 1, 'h020);
    endtask

    task automatic t_clear;
        access('h110, 1, 0); expect_miss("R9", 'h110, 2, 1, 1, 1, 'h060);
        access('h080, 0, 0); expect_miss("R8", 'h080, 3, 0, 2, 1, 'h030);
        access('h090, 0, 0); expect_miss("R8", 'h090, 2, 0, 3, 1, 'h040);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_route();
        t_spill();
        t_probe();
        t_os_evict();
        t_clear();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule